// File: doc/BRIEF.md
# Register-List Walker with Start-Offset Output

This block sits beside the sequencer of a multi-register load/store datapath. A load strobe captures a register-list mask of one bit per register. From the next cycle on, the block reports the index of the lowest register still pending. Each step request retires that register, and the next higher pending one takes its place. When no register is left, a done flag rises, and the sequencer uses it to end the transfer loop or branch out of it. The reported index feeds the register-file read and write port selects.

At load time the block also counts the registers in the list. It presents that count on a 32-bit operand bus, scaled to a byte offset at four bytes per register. A 2-bit selector picks what goes on that bus: nothing, the constant 3, the scaled count, or the scaled count with its two low bits set. The scaled forms give the start-address offset for a block transfer. The constant 3, used with an ALU borrow, subtracts four from a return-address register.

Top module: `reglist_walker`

## Requirements
- R1: After reset the list is empty: `done_o` is 1, `reg_idx_o` is 0 and the stored count is 0, so selector code 3 gives `abus_o` = 3.
- R2: A cycle with `load_i` high captures `list_i`. In the next cycle `reg_idx_o` shows the position of the lowest set bit of that list, and `done_o` is 0 if the list is non-zero.
- R3: A cycle with `step_i` high (and `load_i` low) clears the bit currently reported. The following indices are the remaining set bits in strictly ascending order.
- R4: `done_o` is 1 exactly when no set bit remains. It rises in the cycle after the step that retires the last set bit.
- R5: Loading an all-zero list gives `done_o` = 1 and a count of 0 in the next cycle.
- R6: When `load_i` and `step_i` are both high in one cycle, the load wins. The new list is captured whole, with no bit cleared.
- R7: Selector code 0 drives `abus_o` = 0.
- R8: Selector code 1 drives `abus_o` = 3, whatever the count.
- R9: Selector code 2 drives `abus_o` = 4 × (number of set bits in the last loaded list).
- R10: Selector code 3 drives `abus_o` = 4 × count + 3.
- R11: The count is fixed at load time and does not change while steps consume the list.
- R12: A step while `done_o` is 1 has no effect: `done_o` stays 1 and the code-2 value stays unchanged.
- R13: While `done_o` is 1, `reg_idx_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture `list_i` and its bit count |
| list_i | input | 16 | Register-list mask, bit n = register n |
| step_i | input | 1 | Retire the currently reported register |
| abus_sel_i | input | 2 | Operand selector: 0 zero, 1 three, 2 count×4, 3 count×4+3 |
| reg_idx_o | output | 4 | Index of the lowest pending register |
| done_o | output | 1 | No register pending |
| abus_o | output | 32 | Selected operand value |

## Verification
The bench sweeps every single-bit list, the all-zero and all-one lists and several hundred pseudo-random lists. For each one it follows the index sequence to exhaustion and compares every index with a lowest-bit model. If the encoder picked the highest bit or failed to clear a bit, the order would come out wrong or would repeat an index. An off-by-one on the done flag would show up either as a missing last register or as an extra phantom step. The bench also steps on after exhaustion and issues a load and a step in the same cycle. A count that tracked the live mask instead of the loaded one would make the scaled value drift down during the walk. A step given priority over load would lose bit 0 of the new list.

// File: rtl/reglist_pkg.sv
package reglist_pkg;
  typedef enum logic [1:0] {
    ABUS_ZERO   = 2'd0,
    ABUS_THREE  = 2'd1,
    ABUS_CNT    = 2'd2,
    ABUS_CNT_P3 = 2'd3
  } abus_sel_e;
endpackage

// File: rtl/reglist_lowbit.sv
module reglist_lowbit #(
  parameter int LIST_W = 16,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] bits_i,
  output logic [LIST_W-1:0] onehot_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              none_o
);
  logic [LIST_W:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < LIST_W; i++) begin : g_prefix
    assign seen[i+1]   = seen[i] | bits_i[i];
    assign onehot_o[i] = bits_i[i] & ~seen[i];
  end

  assign none_o = ~seen[LIST_W];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LIST_W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/reglist_popcnt.sv
module reglist_popcnt #(
  parameter int LIST_W = 16,
  localparam int CNT_W = $clog2(LIST_W + 1)
) (
  input  logic [LIST_W-1:0] bits_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] part [LIST_W+1];

  assign part[0] = '0;
  for (genvar i = 0; i < LIST_W; i++) begin : g_acc
    assign part[i+1] = part[i] + CNT_W'(bits_i[i]);
  end

  assign cnt_o = part[LIST_W];
endmodule

// File: rtl/reglist_abus.sv
module reglist_abus
  import reglist_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] value_o
);
  logic [DATA_W-1:0] scaled;

  // one word (4 bytes) per register
  assign scaled = DATA_W'(cnt_i) << 2;

  always_comb begin
    case (abus_sel_e'(sel_i))
      ABUS_ZERO:   value_o = '0;
      ABUS_THREE:  value_o = DATA_W'(3);
      ABUS_CNT:    value_o = scaled;
      ABUS_CNT_P3: value_o = scaled | DATA_W'(3);
      default:     value_o = '0;
    endcase
  end
endmodule

// File: rtl/reglist_walker.sv
module reglist_walker #(
  parameter int LIST_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LIST_W),
  localparam int CNT_W = $clog2(LIST_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic              step_i,
  input  logic [1:0]        abus_sel_i,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              done_o,
  output logic [DATA_W-1:0] abus_o
);
  logic [LIST_W-1:0] list_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_load;
  logic [LIST_W-1:0] low_onehot;

  reglist_popcnt #(.LIST_W(LIST_W)) u_popcnt (
    .bits_i (list_i),
    .cnt_o  (cnt_load)
  );

  reglist_lowbit #(.LIST_W(LIST_W)) u_lowbit (
    .bits_i   (list_q),
    .onehot_o (low_onehot),
    .idx_o    (reg_idx_o),
    .none_o   (done_o)
  );

  reglist_abus #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_abus (
    .cnt_i   (cnt_q),
    .sel_i   (abus_sel_i),
    .value_o (abus_o)
  );

  // load beats step; count frozen until next load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      list_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      list_q <= list_i;
      cnt_q  <= cnt_load;
    end else if (step_i) begin
      list_q <= list_q & ~low_onehot;
    end
  end
endmodule

// File: rtl/reglist_walker_chk.sv
module reglist_walker_chk #(
  parameter int LIST_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [LIST_W-1:0] list_i,
  input logic              step_i,
  input logic [1:0]        abus_sel_i,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              done_o,
  input logic [DATA_W-1:0] abus_o
);
  AST_LOAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && list_i == '0) |=> done_o);                             // R5
  AST_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && list_i != '0) |=> !done_o);                            // R2
  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !done_o) |=> (done_o || reg_idx_o > $past(reg_idx_o))); // R3
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);                                  // R12
  AST_IDLE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> reg_idx_o == '0);                                      // R13
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && abus_sel_i[1]) |=> (!abus_sel_i[1] || $stable(abus_o[DATA_W-1:2]))); // R11
  AST_NO_STEP_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && step_i && list_i[0]) |=> reg_idx_o == '0);             // R6
endmodule

bind reglist_walker reglist_walker_chk #(.LIST_W(LIST_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .list_i     (list_i),
  .step_i     (step_i),
  .abus_sel_i (abus_sel_i),
  .reg_idx_o  (reg_idx_o),
  .done_o     (done_o),
  .abus_o     (abus_o)
);

// File: tb/reglist_walker_bench.sv
module reglist_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] list = '0;
  logic        step = 1'b0;
  logic [1:0]  sel = '0;
  logic [3:0]  idx;
  logic        done;
  logic [31:0] abus;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reglist_walker u_reglist_walker (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .load_i     (load),
    .list_i     (list),
    .step_i     (step),
    .abus_sel_i (sel),
    .reg_idx_o  (idx),
    .done_o     (done),
    .abus_o     (abus)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int low_of(input logic [15:0] m);
    for (int i = 15; i >= 0; i--) if (m[i]) low_of = i;
    if (m == 0) low_of = 0;
  endfunction

  function automatic int pop_of(input logic [15:0] m);
    pop_of = 0;
    for (int i = 0; i < 16; i++) pop_of += int'(m[i]);
  endfunction

  task automatic check_codes(input int cnt);
    sel = 2'd0; #1; chk("R7",  abus, 32'd0);
    sel = 2'd1; #1; chk("R8",  abus, 32'd3);
    sel = 2'd2; #1; chk("R9",  abus, 32'(cnt * 4));
    sel = 2'd3; #1; chk("R10", abus, 32'(cnt * 4 + 3));
    sel = 2'd2;
  endtask

  task automatic walk(input logic [15:0] l);
    logic [15:0] m;
    int cnt;
    m = l;
    cnt = pop_of(l);
    @(negedge clk);
    load = 1'b1; list = l; step = 1'b0;
    @(negedge clk);
    load = 1'b0;
    chk(l == 0 ? "R5" : "R2", {31'd0, done}, {31'd0, l == 0});
    chk("R2", {28'd0, idx}, 32'(low_of(l)));
    check_codes(cnt);
    while (m != 0) begin
      chk("R3", {28'd0, idx}, 32'(low_of(m)));
      chk("R4", {31'd0, done}, 32'd0);
      step = 1'b1;
      m = m & ~(16'd1 << low_of(m));
      @(negedge clk);
      step = 1'b0;
      #1;
      chk("R11", abus, 32'(cnt * 4));
    end
    chk("R4", {31'd0, done}, 32'd1);
    chk("R13", {28'd0, idx}, 32'd0);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    #1;
    chk("R12", {31'd0, done}, 32'd1);
    chk("R12", abus, 32'(cnt * 4));
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, done}, 32'd1);
    chk("R1", {28'd0, idx}, 32'd0);
    sel = 2'd3; #1;
    chk("R1", abus, 32'd3);

    walk(16'h0000);
    walk(16'hFFFF);
    walk(16'h8001);
    walk(16'hAAAA);
    for (int b = 0; b < 16; b++) walk(16'd1 << b);

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      walk(lfsr);
    end

    // R6: load and step together, new list whole
    @(negedge clk);
    load = 1'b1; list = 16'h00F0;
    @(negedge clk);
    list = 16'h0003; step = 1'b1;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    chk("R6", {28'd0, idx}, 32'd0);
    sel = 2'd2; #1;
    chk("R6", abus, 32'd8);
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk("R6", {28'd0, idx}, 32'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule